// File: doc/BRIEF.md
# Vector Condition-Truncated In-Order Commit

This block sits at the retirement end of a vector pipeline. Element results reach it in any order, each tagged with its element index, a one-bit test outcome and a data word. It parks each result in a per-element slot. A commit pointer then walks the slots strictly from element 0 upward. Nothing reaches the register file write port until the pointer has reached that element and its test outcome has been examined.

An element fails when its test bit equals a sense bit chosen at the start of the operation. At the first failure in element order the walk stops. That element and every element beyond it are discarded. The reported vector length becomes the index of the failing element. When no element fails, the full length is reported.

A keep-one option serves the load/store style of the operation, where the length must never collapse to zero. With this option a failure at element 0 is treated as a pass. The block reports its result with a single-cycle done pulse. It also provides an accumulated mask of the elements that were written.

Top module: `vff_trunc`

## Requirements
- R1: After reset, wr_en_o, done_o and busy_o are 0, mask_o is all zero and new_vl_o is 0.
- R2: A start_i pulse loads vl_i, sense_i and keep_one_i, clears all parked elements and mask_o, sets new_vl_o to 0 and raises busy_o on the next cycle. An element strobe is ignored in each of these cases: it arrives in the start cycle, it arrives while busy_o is 0, or its index is not below the loaded length.
- R3: Writes leave on wr_en_o/wr_idx_o/wr_data_o one per cycle at most. The indices run 0, 1, 2, … with no gaps. wr_data_o is the data word parked for that index.
- R4: The commit pointer stalls at an element that has not yet arrived, even when later elements have already arrived.
- R5: An element fails when its condition bit equals the loaded sense bit. That element and all later ones are never written. new_vl_o becomes the failing index.
- R6: If no element fails, new_vl_o equals the loaded length. done_o rises one cycle after the last write.
- R7: With keep_one set, a failing element 0 is written as if it had passed. A failure at any later index still truncates, so new_vl_o is never 0 for a nonzero length.
- R8: Bit i of mask_o sets in the cycle element i is written. At done_o, the number of set bits in mask_o equals new_vl_o.
- R9: A loaded length of 0 finishes with new_vl_o = 0, even with keep_one set. A vl_i above MAX_VL is clamped to MAX_VL.
- R10: done_o is a one-cycle pulse. busy_o is 0 whenever done_o is 1. A write never occurs while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new operation |
| vl_i | input | 7 | Original vector length (clamped to MAX_VL) |
| sense_i | input | 1 | Condition value that counts as failure |
| keep_one_i | input | 1 | Element 0 may not fail |
| elem_valid_i | input | 1 | Element result strobe |
| elem_idx_i | input | 6 | Element index |
| elem_cond_i | input | 1 | Element test bit |
| elem_data_i | input | 32 | Element result |
| wr_en_o | output | 1 | Register file write enable |
| wr_idx_o | output | 6 | Element index written |
| wr_data_o | output | 32 | Data written |
| mask_o | output | 64 | Written-element mask |
| new_vl_o | output | 7 | Truncated vector length |
| done_o | output | 1 | Operation finished (one cycle) |
| busy_o | output | 1 | Operation in progress |

## Verification
The main function is tried in four settings. First, results arrive in element order with all passing, which gives a full-length result. Second, results arrive in reverse order with a mid-vector failure, which separates in-order commit from arrival order. Third, a hole at element 0 leaves later elements waiting, which shows the stall. Fourth, the same failure pattern at element 0 is run with and without keep-one, which isolates that option. Zero and over-range lengths, and strobes that must be ignored, are also applied. A behavioural model with queues and integers predicts every output on every cycle.

// File: rtl/vff_pkg.sv
package vff_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

   function automatic int unsigned clamp_len(int unsigned req, int unsigned max_len);
      return (req > max_len) ? max_len : req;
   endfunction
endpackage

// File: rtl/vff_elem_buf.sv
module vff_elem_buf #(
   parameter int DEPTH      = 64,
   parameter int DATA_W     = 32,
   parameter bit RESET_DATA = 1'b0,
   localparam int IDXW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic              wr_cond,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDXW-1:0]   rd_idx,
   output logic              rd_valid,
   output logic              rd_cond,
   output logic [DATA_W-1:0] rd_data
);
   logic [DEPTH-1:0]  vld_vec;
   logic [DEPTH-1:0]  cond_vec;
   logic [DATA_W-1:0] data_arr [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              v_q, c_q;
      logic [DATA_W-1:0] d_q;
      logic              hit;
      assign hit = wr_en && (wr_idx == IDXW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            c_q <= 1'b0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (hit) begin
            v_q <= 1'b1;
            c_q <= wr_cond;
         end
      end

      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   d_q <= '0;
            else if (hit) d_q <= wr_data;
         end
      end else begin : g_plain_data
         always_ff @(posedge clk) begin
            if (hit) d_q <= wr_data;
         end
      end

      assign vld_vec[i]  = v_q;
      assign cond_vec[i] = c_q;
      assign data_arr[i] = d_q;
   end

   assign rd_valid = vld_vec[rd_idx];
   assign rd_cond  = cond_vec[rd_idx];
   assign rd_data  = data_arr[rd_idx];
endmodule

// File: rtl/vff_mask_acc.sv
module vff_mask_acc #(
   parameter int DEPTH = 64,
   localparam int IDXW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set_en,
   input  logic [IDXW-1:0]  set_idx,
   output logic [DEPTH-1:0] mask
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 mask[i] <= 1'b0;
         else if (clr)                               mask[i] <= 1'b0;
         else if (set_en && (set_idx == IDXW'(i)))   mask[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/vff_commit_ctrl.sv
module vff_commit_ctrl
   import vff_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 32,
   localparam int IDXW  = $clog2(DEPTH),
   localparam int VLW   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    len,
   input  logic              sense,
   input  logic              keep_one,
   input  logic              slot_valid,
   input  logic              slot_cond,
   input  logic [DATA_W-1:0] slot_data,
   output logic [IDXW-1:0]   slot_idx,
   output logic              commit,
   output logic              running,
   output logic              wr_en,
   output logic [IDXW-1:0]   wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [VLW-1:0]    new_vl,
   output logic              done
);
   run_state_e     state_q;
   logic [VLW-1:0] ptr_q;
   logic           at_end, fails, finish;

   assign running  = (state_q == ST_RUN);
   assign slot_idx = ptr_q[IDXW-1:0];
   assign at_end   = (ptr_q == len);
   assign fails    = (slot_cond == sense) && !(keep_one && (ptr_q == '0));
   assign finish   = running && !start && (at_end || (slot_valid && fails));
   assign commit   = running && !start && !at_end && slot_valid && !fails;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
         new_vl  <= '0;
         done    <= 1'b0;
      end else if (start) begin
         state_q <= ST_RUN;
         ptr_q   <= '0;
         wr_en   <= 1'b0;
         new_vl  <= '0;
         done    <= 1'b0;
      end else begin
         wr_en <= commit;
         done  <= finish;
         if (commit) begin
            wr_idx  <= slot_idx;
            wr_data <= slot_data;
            ptr_q   <= ptr_q + VLW'(1);
         end
         if (finish) begin
            state_q <= ST_IDLE;
            new_vl  <= ptr_q;
         end
      end
   end
endmodule

// File: rtl/vff_trunc.sv
module vff_trunc
   import vff_pkg::*;
#(
   parameter int MAX_VL     = 64,
   parameter int DATA_W     = 32,
   parameter bit RESET_DATA = 1'b0,
   localparam int IDXW      = $clog2(MAX_VL),
   localparam int VLW       = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VLW-1:0]    vl_i,
   input  logic              sense_i,
   input  logic              keep_one_i,
   input  logic              elem_valid_i,
   input  logic [IDXW-1:0]   elem_idx_i,
   input  logic              elem_cond_i,
   input  logic [DATA_W-1:0] elem_data_i,
   output logic              wr_en_o,
   output logic [IDXW-1:0]   wr_idx_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [MAX_VL-1:0] mask_o,
   output logic [VLW-1:0]    new_vl_o,
   output logic              done_o,
   output logic              busy_o
);
   if (MAX_VL < 2) begin : g_bad_len
      $error("vff_trunc: MAX_VL must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("vff_trunc: DATA_W must be positive");
   end

   logic [VLW-1:0]    vl_q;
   logic              sense_q, keep_q;
   logic              buf_we, slot_valid, slot_cond, commit, running;
   logic [IDXW-1:0]   slot_idx;
   logic [DATA_W-1:0] slot_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q    <= '0;
         sense_q <= 1'b0;
         keep_q  <= 1'b0;
      end else if (start_i) begin
         vl_q    <= VLW'(clamp_len(int'(vl_i), MAX_VL));
         sense_q <= sense_i;
         keep_q  <= keep_one_i;
      end
   end

   assign buf_we = elem_valid_i && running && !start_i && (VLW'(elem_idx_i) < vl_q);
   assign busy_o = running;

   vff_elem_buf #(.DEPTH(MAX_VL), .DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start_i),
      .wr_en    (buf_we),
      .wr_idx   (elem_idx_i),
      .wr_cond  (elem_cond_i),
      .wr_data  (elem_data_i),
      .rd_idx   (slot_idx),
      .rd_valid (slot_valid),
      .rd_cond  (slot_cond),
      .rd_data  (slot_data)
   );

   vff_commit_ctrl #(.DEPTH(MAX_VL), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .len        (vl_q),
      .sense      (sense_q),
      .keep_one   (keep_q),
      .slot_valid (slot_valid),
      .slot_cond  (slot_cond),
      .slot_data  (slot_data),
      .slot_idx   (slot_idx),
      .commit     (commit),
      .running    (running),
      .wr_en      (wr_en_o),
      .wr_idx     (wr_idx_o),
      .wr_data    (wr_data_o),
      .new_vl     (new_vl_o),
      .done       (done_o)
   );

   vff_mask_acc #(.DEPTH(MAX_VL)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_i),
      .set_en  (commit),
      .set_idx (slot_idx),
      .mask    (mask_o)
   );
endmodule

// File: rtl/vff_trunc_chk.sv
module vff_trunc_chk #(
   parameter int MAX_VL = 64,
   localparam int IDXW  = $clog2(MAX_VL),
   localparam int VLW   = $clog2(MAX_VL + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_o,
   input logic [IDXW-1:0]   wr_idx_o,
   input logic [MAX_VL-1:0] mask_o,
   input logic [VLW-1:0]    new_vl_o,
   input logic              done_o,
   input logic              busy_o,
   input logic              keep_q,
   input logic [VLW-1:0]    vl_q
);
   AST_WRITE_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (($countones(mask_o) == int'(wr_idx_o) + 1) && mask_o[wr_idx_o])); // R3
   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> busy_o); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R10
   AST_MASK_MATCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones(mask_o) == int'(new_vl_o))); // R8
   AST_KEEP_ONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && keep_q && (vl_q != '0)) |-> (new_vl_o != '0)); // R7
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (new_vl_o <= vl_q)); // R5
endmodule

bind vff_trunc vff_trunc_chk #(.MAX_VL(MAX_VL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en_o  (wr_en_o),
   .wr_idx_o (wr_idx_o),
   .mask_o   (mask_o),
   .new_vl_o (new_vl_o),
   .done_o   (done_o),
   .busy_o   (busy_o),
   .keep_q   (keep_q),
   .vl_q     (vl_q)
);

// File: tb/vff_trunc_tb.sv
module vff_trunc_tb;
   localparam int MAXV = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [6:0]  vl_i = '0;
   logic        sense_i = 1'b0, keep_one_i = 1'b0;
   logic        elem_valid_i = 1'b0;
   logic [5:0]  elem_idx_i = '0;
   logic        elem_cond_i = 1'b0;
   logic [31:0] elem_data_i = '0;
   logic        wr_en_o, done_o, busy_o;
   logic [5:0]  wr_idx_o;
   logic [31:0] wr_data_o;
   logic [63:0] mask_o;
   logic [6:0]  new_vl_o;

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   vff_trunc u_dut (.*);

   // behavioural reference model
   bit          m_valid [MAXV];
   bit          m_cond  [MAXV];
   logic [31:0] m_data  [MAXV];
   int          m_ptr = 0, m_vl = 0, m_newvl = 0, m_idx = 0;
   bit          m_run = 0, m_sense = 0, m_keep = 0, m_done = 0, m_wr = 0;
   logic [31:0] m_wdata = '0;
   logic [63:0] m_mask = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_done = 0; m_wr = 0; m_mask = '0; m_newvl = 0; m_ptr = 0;
      end else begin
         bit run_before;
         run_before = m_run;
         m_done = 0; m_wr = 0;
         if (start_i) begin
            m_vl = (int'(vl_i) > MAXV) ? MAXV : int'(vl_i);
            m_sense = sense_i; m_keep = keep_one_i;
            m_ptr = 0; m_run = 1; m_mask = '0; m_newvl = 0;
            foreach (m_valid[i]) m_valid[i] = 0;
         end else begin
            if (m_run) begin
               if (m_ptr == m_vl) begin
                  m_done = 1; m_run = 0; m_newvl = m_vl;
               end else if (m_valid[m_ptr]) begin
                  if (m_cond[m_ptr] == m_sense && !(m_keep && m_ptr == 0)) begin
                     m_done = 1; m_run = 0; m_newvl = m_ptr;
                  end else begin
                     m_wr = 1; m_idx = m_ptr; m_wdata = m_data[m_ptr];
                     m_mask[m_ptr] = 1'b1; m_ptr++;
                  end
               end
            end
            if (elem_valid_i && run_before && int'(elem_idx_i) < m_vl) begin
               m_valid[elem_idx_i] = 1; m_cond[elem_idx_i] = elem_cond_i;
               m_data[elem_idx_i] = elem_data_i;
            end
         end
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 wr_en", 64'(wr_en_o), 64'(m_wr));
         if (m_wr) begin
            chk("R3 wr_idx", 64'(wr_idx_o), 64'(m_idx));
            chk("R3 wr_data", 64'(wr_data_o), 64'(m_wdata));
         end
         chk("R8 mask", mask_o, m_mask);
         chk("R5 new_vl", 64'(new_vl_o), 64'(m_newvl));
         chk("R10 done", 64'(done_o), 64'(m_done));
         chk("R2 busy", 64'(busy_o), 64'(m_run));
      end
   end

   task automatic do_start(int len, bit sense, bit keep);
      start_i = 1; vl_i = 7'(len); sense_i = sense; keep_one_i = keep;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic send(int idx, bit cond);
      elem_valid_i = 1; elem_idx_i = 6'(idx); elem_cond_i = cond;
      elem_data_i = 32'hC0DE_0000 ^ (32'(idx) * 32'h0001_0101) ^ 32'(checks);
      @(negedge clk);
      elem_valid_i = 0;
   endtask

   task automatic wait_done();
      for (int n = 0; n < 400; n++) begin
         if (done_o) return;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 wr_en", 64'(wr_en_o), 0);
      chk("R1 done", 64'(done_o), 0);
      chk("R1 busy", 64'(busy_o), 0);
      chk("R1 mask", mask_o, 0);
      chk("R1 new_vl", 64'(new_vl_o), 0);
      rst_n = 1;
      @(negedge clk);

      // R6 in-order arrival, all pass
      do_start(8, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) send(i, 1'b0);
      wait_done();
      chk("R6 full length", 64'(new_vl_o), 8);
      chk("R6 full mask", mask_o, 64'hFF);

      // R5 reverse arrival, failure at 5
      do_start(8, 1'b1, 1'b0);
      for (int i = 7; i >= 0; i--) send(i, i == 5);
      wait_done();
      chk("R5 truncated length", 64'(new_vl_o), 5);
      chk("R5 mask below failure", mask_o, 64'h1F);

      // R4 stall on missing element 0
      do_start(4, 1'b1, 1'b0);
      for (int i = 1; i < 4; i++) send(i, 1'b0);
      repeat (5) @(negedge clk);
      chk("R4 stalled mask", mask_o, 0);
      chk("R4 still busy", 64'(busy_o), 1);
      send(0, 1'b0);
      wait_done();
      chk("R4 length after stall", 64'(new_vl_o), 4);

      // R7 keep-one: element 0 fails but commits, element 3 truncates
      do_start(6, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) send(i, !(i == 0 || i == 3));
      wait_done();
      chk("R7 keep-one length", 64'(new_vl_o), 3);
      chk("R7 keep-one mask", mask_o, 64'h7);
      // R5 same pattern without keep-one
      do_start(6, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) send(i, !(i == 0 || i == 3));
      wait_done();
      chk("R5 fail at element 0", 64'(new_vl_o), 0);
      chk("R5 nothing written", mask_o, 0);
      // R7 single element, failing, keep-one
      do_start(1, 1'b1, 1'b1);
      send(0, 1'b1);
      wait_done();
      chk("R7 single element kept", 64'(new_vl_o), 1);

      // R9 zero length and clamp
      do_start(0, 1'b1, 1'b1);
      wait_done();
      chk("R9 zero length", 64'(new_vl_o), 0);
      do_start(100, 1'b1, 1'b0);
      for (int i = 0; i < 64; i++) send(i, 1'b0);
      wait_done();
      chk("R9 clamped length", 64'(new_vl_o), 64);
      chk("R9 clamped mask", mask_o, 64'hFFFF_FFFF_FFFF_FFFF);

      // R2 ignored strobes: idle, start cycle, out of range
      repeat (2) @(negedge clk);
      send(0, 1'b0);
      elem_valid_i = 1; elem_idx_i = 0; elem_cond_i = 0;
      do_start(2, 1'b1, 1'b0);
      elem_valid_i = 0;
      send(1, 1'b0);
      send(3, 1'b1);
      repeat (4) @(negedge clk);
      chk("R2 idle/start strobes ignored", mask_o, 0);
      send(0, 1'b0);
      wait_done();
      chk("R2 length after ignored strobes", 64'(new_vl_o), 2);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule